// File: doc/BRIEF.md
# Diagnostic Reset Unlock Sequencer

This block keeps an adapter soft reset locked until the host proves intent. The host writes a fixed six-value key into a sequence register, one value per write. Each write that matches the expected key value moves a position counter forward. A write that does not match sends the counter back to the start. After the sixth correct value the diagnostic register shows a write-enable flag.

While that flag is set, a write to the diagnostic register with its reset bit set fires a single-cycle soft-reset pulse. The same write returns the sequencer to its idle state. Without the flag, a reset request is ignored. A wrong key write at any time clears the flag again. The diagnostic register can be read at any time on a dedicated output.

Top module: `diag_unlock`

## Requirements
- R1: After the asynchronous reset, `diag_o` reads 0, `soft_reset_o` is low and the key position is 0.
- R2: The key is 0x00, 0x04, 0x0B, 0x02, 0x07, 0x0D, written in that order to the sequence offset 0x34. Each write is compared over the full 32-bit data word. In the cycle after the sixth matching write, `diag_o` reads 0x80 (write-enable, bit 7).
- R3: A prefix of fewer than six matching writes leaves `diag_o` at 0.
- R4: A sequence write that does not match the key at the current position sets the position to 0. The mismatching value is not then tried as the first key, so 0x00 written at a later position does not count as step one.
- R5: A mismatching sequence write while write-enable is set clears `diag_o` to 0 in the next cycle.
- R6: Once unlocked, the position saturates. Further sequence writes are compared against the first key value (0x00). Writing 0x00 keeps write-enable set.
- R7: A write to the diagnostic offset 0xF8 with data bit 2 set, while `diag_o` bit 7 is set, raises `soft_reset_o` for exactly one cycle, starting in the next cycle. The same write clears `diag_o` and the key position.
- R8: A diagnostic write while locked, or a diagnostic write without bit 2, produces no pulse and leaves `diag_o` unchanged.
- R9: Writes to any other offset, and cycles with `wr_en_i` low, leave the key position and `diag_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write byte offset |
| wr_data_i | input | 32 | Register write data |
| diag_o | output | 32 | Current diagnostic register value |
| soft_reset_o | output | 1 | Single-cycle adapter soft-reset pulse |

## Verification
The embedded assertions check these properties on every cycle:
- The pulse is one cycle wide and is only ever preceded by a held write-enable.
- The diagnostic register takes only the values 0 and 0x80.
- The position counter never passes six.
- The counter returns to zero after a mismatch and holds still when no sequence write occurs.

The order of the key, the full-width comparison, and the fact that a mismatching 0x00 is not taken as a fresh start are shown only by the bench scenarios. The bench sweeps every low-byte value at every position.

// File: rtl/diag_unlock_pkg.sv
package diag_unlock_pkg;
  localparam int KEY_LEN = 6;
  localparam int CNT_W   = $clog2(KEY_LEN + 1);
  localparam int WE_BIT  = 7;
  localparam int RST_BIT = 2;

  function automatic logic [7:0] key_at(input logic [CNT_W-1:0] idx);
    case (idx)
      3'd0:    key_at = 8'h00;
      3'd1:    key_at = 8'h04;
      3'd2:    key_at = 8'h0B;
      3'd3:    key_at = 8'h02;
      3'd4:    key_at = 8'h07;
      3'd5:    key_at = 8'h0D;
      default: key_at = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/seq_tracker.sv
module seq_tracker
  import diag_unlock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seq_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clr_i,
  output logic              grant_o,
  output logic              revoke_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(KEY_LEN);

  logic [CNT_W-1:0]  cnt_q, cnt_d, idx;
  logic [DATA_W-1:0] exp_w;
  logic              match;

  // saturated counter compares against the first key again
  assign idx = (cnt_q == FULL) ? '0 : cnt_q;

  always_comb begin
    exp_w      = '0;
    exp_w[7:0] = key_at(idx);
  end

  assign match    = (data_i == exp_w);
  assign grant_o  = seq_wr_i && match && (cnt_q == FULL - 1'b1);
  assign revoke_o = seq_wr_i && !match;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (seq_wr_i)
      cnt_d = !match ? '0 : (cnt_q == FULL) ? cnt_q : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  assert_mismatch_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    revoke_o |=> cnt_q == '0);
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seq_wr_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/diag_ctrl.sv
module diag_ctrl
  import diag_unlock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              diag_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              grant_i,
  input  logic              revoke_i,
  output logic              fire_o,
  output logic [DATA_W-1:0] diag_o,
  output logic              soft_reset_o
);
  localparam logic [DATA_W-1:0] WE_VAL = DATA_W'(1) << WE_BIT;

  logic [DATA_W-1:0] diag_q, diag_d;
  logic              pulse_q;

  assign fire_o = diag_wr_i && diag_q[WE_BIT] && data_i[RST_BIT];

  always_comb begin
    diag_d = diag_q;
    if (fire_o || revoke_i) diag_d = '0;
    else if (grant_i)       diag_d = WE_VAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      diag_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      diag_q  <= diag_d;
      pulse_q <= fire_o;
    end

  assign diag_o       = diag_q;
  assign soft_reset_o = pulse_q;

  assert_pulse_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_reset_o |=> !soft_reset_o);
  assert_pulse_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_reset_o |-> $past(diag_q) == WE_VAL);
  assert_diag_values_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diag_q == '0 || diag_q == WE_VAL);
  assert_revoke_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    revoke_i |=> diag_q == '0);
endmodule

// File: rtl/diag_unlock.sv
module diag_unlock
  import diag_unlock_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 32,
  parameter logic [ADDR_W-1:0] SEQ_OFS  = 8'h34,
  parameter logic [ADDR_W-1:0] DIAG_OFS = 8'hF8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] diag_o,
  output logic              soft_reset_o
);
  logic seq_wr, diag_wr, grant, revoke, fire;

  assign seq_wr  = wr_en_i && (wr_addr_i == SEQ_OFS);
  assign diag_wr = wr_en_i && (wr_addr_i == DIAG_OFS);

  seq_tracker #(.DATA_W(DATA_W)) tracker_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .seq_wr_i (seq_wr),
    .data_i   (wr_data_i),
    .clr_i    (fire),
    .grant_o  (grant),
    .revoke_o (revoke)
  );

  diag_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .diag_wr_i    (diag_wr),
    .data_i       (wr_data_i),
    .grant_i      (grant),
    .revoke_i     (revoke),
    .fire_o       (fire),
    .diag_o       (diag_o),
    .soft_reset_o (soft_reset_o)
  );

  assert_reset_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_reset_o |-> diag_o == '0);
endmodule

// File: tb/diag_unlock_tb_top.sv
module diag_unlock_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] diag;
  logic        srst;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [7:0] SEQ  = 8'h34;
  localparam logic [7:0] DIAG = 8'hF8;
  localparam logic [7:0] KEYS [6] = '{8'h00, 8'h04, 8'h0B, 8'h02, 8'h07, 8'h0D};

  always #10 clk = ~clk;

  diag_unlock dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .diag_o(diag), .soft_reset_o(srst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, return at the negedge after the capturing edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic unlock();
    for (int k = 0; k < 6; k++) wr(SEQ, 32'(KEYS[k]));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 diag", diag, 32'h0);
    check("R1 pulse", 32'(srst), 32'h0);
    rst_n = 1'b1;
    idle();
    check("R1 diag after release", diag, 32'h0);

    // R2 / R3: sweep every low byte at every position
    for (int p = 0; p < 6; p++) begin
      for (int v = 0; v < 256; v++) begin
        logic [31:0] exp;
        for (int k = 0; k < p; k++) wr(SEQ, 32'(KEYS[k]));
        wr(SEQ, 32'(v));
        exp = (p == 5 && v == 8'h0D) ? 32'h80 : 32'h0;
        check(p == 5 ? "R2 sweep" : "R3 sweep", diag, exp);
        if (exp != 0) begin
          wr(DIAG, 32'h4);
          check("R7 sweep pulse", 32'(srst), 32'h1);
        end else begin
          wr(SEQ, 32'hFFFF_FFFF);
        end
      end
    end

    // R2: upper bits count in the comparison
    for (int k = 0; k < 5; k++) wr(SEQ, 32'(KEYS[k]));
    wr(SEQ, 32'h0000_010D);
    check("R2 full-width compare", diag, 32'h0);
    wr(SEQ, 32'hFFFF_FFFF);

    // R4: a mismatching 0x00 does not restart as step one
    wr(SEQ, 32'h00); wr(SEQ, 32'h04); wr(SEQ, 32'h00);
    for (int k = 1; k < 6; k++) wr(SEQ, 32'(KEYS[k]));
    check("R4 no fresh start", diag, 32'h0);
    unlock();
    check("R4 restart then full key", diag, 32'h80);

    // R6: saturation, first key keeps the enable
    wr(SEQ, 32'h00);
    check("R6 hold on key0", diag, 32'h80);
    wr(SEQ, 32'h00);
    check("R6 hold twice", diag, 32'h80);
    // R5: wrong value revokes
    wr(SEQ, 32'h04);
    check("R5 revoke", diag, 32'h0);
    wr(DIAG, 32'h4);
    check("R8 reset after revoke ignored", 32'(srst), 32'h0);

    // R8: locked or missing bit 2
    wr(DIAG, 32'hFFFF_FFFF);
    check("R8 locked pulse", 32'(srst), 32'h0);
    check("R8 locked diag", diag, 32'h0);
    unlock();
    wr(DIAG, 32'hFFFF_FFFB);
    check("R8 no bit2 pulse", 32'(srst), 32'h0);
    check("R8 no bit2 diag", diag, 32'h80);

    // R9: other offsets and idle strobe
    wr(8'hF4, 32'h4); wr(8'h30, 32'h04); wr(8'h00, 32'hFFFF_FFFF);
    @(negedge clk); wr_addr = SEQ; wr_data = 32'h99; idle();
    check("R9 other offsets keep diag", diag, 32'h80);
    wr(DIAG, 32'h0); wr(SEQ, 32'hFFFF_FFFF);
    for (int k = 0; k < 6; k++) begin
      wr(SEQ, 32'(KEYS[k]));
      wr(8'h38, 32'hDEAD_BEEF);
      wr(8'hF8 ^ 8'h01, 32'h0);
    end
    check("R9 interleaved unlock", diag, 32'h80);

    // R7: pulse timing and clear
    wr(DIAG, 32'h4);
    check("R7 pulse high", 32'(srst), 32'h1);
    check("R7 diag cleared", diag, 32'h0);
    idle();
    check("R7 pulse one cycle", 32'(srst), 32'h0);
    wr(SEQ, 32'h0D);
    check("R7 counter cleared", diag, 32'h0);
    wr(SEQ, 32'hFFFF_FFFF);
    unlock();
    check("R7 relock works", diag, 32'h80);

    // R1: async reset mid-sequence
    wr(SEQ, 32'h00); wr(SEQ, 32'h04);
    @(negedge clk); rst_n = 1'b0; @(negedge clk);
    check("R1 async diag", diag, 32'h0);
    rst_n = 1'b1;
    for (int k = 2; k < 6; k++) wr(SEQ, 32'(KEYS[k]));
    check("R1 counter cleared", diag, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule